// File: doc/BRIEF.md
# Byte-wide downward stack controller

This block owns a stack pointer and turns stack commands into byte accesses on a single-port memory. The stack grows toward address zero. The pointer always names the most recently stored byte. A push moves the pointer down before it writes, and a pull reads at the pointer before it moves up. Values of sixteen bits are kept with the high byte at the lower address. A word push or pull therefore takes two memory beats in a fixed order, and a subroutine call or return is the same word transfer of a return address.

Commands enter on a valid/ready handshake. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low only during the second beat of a word operation. A command presented in that cycle is not taken and has no effect. If the source keeps it valid, it is taken in the first cycle that `cmd_ready` returns. The pulled word and the `done` pulse are plain outputs and take no back-pressure.

The memory read is combinational: `mem_rdata` must reflect `mem_addr` in the same cycle. A write takes effect at the clock edge while `mem_we` is high.

Top module: `byte_stack_ctrl`

## Requirements
- R1: After reset the pointer equals RESET_SP (default 16'h1000). `busy`, `done` and `mem_we` are 0, and `cmd_ready` is 1.
- R2: Op code 7 (load) sets the pointer to `cmd_data` on the accepting edge. It writes no memory and raises `done` for one cycle in the following cycle.
- R3: Op code 1 (byte push) behaves as follows in the accepting cycle:
  - it writes `cmd_data[7:0]` at pointer-1;
  - the pointer becomes pointer-1;
  - `done` pulses in the next cycle.
- R4: Op code 3 (byte pull) reads the byte at the pointer in the accepting cycle, and the pointer becomes pointer+1. In the next cycle, `done` pulses and `pull_data` shows {8'h00, byte}.
- R5: Op code 2 (word push) and op code 5 (call, whose `cmd_data` is the return address) each take two beats:
  - in the accepting cycle, the low byte is written at pointer-1;
  - in the next cycle, the high byte is written at pointer-2;
  - the pointer ends at pointer-2, and `done` pulses in the cycle after the second write.
- R6: Op code 4 (word pull) and op code 6 (return) each take two beats:
  - they read the high byte at the pointer and then the low byte at pointer+1;
  - the pointer ends at pointer+2;
  - `pull_data` shows {high, low} in the cycle where `done` pulses, and holds that value until the next pull completes.
- R7: During the second beat of a word operation, `busy` is 1 and `cmd_ready` is 0. A command presented then changes neither the pointer nor memory in that cycle.
- R8: In every other cycle `cmd_ready` is 1, so a command can be taken in the same cycle as the previous `done`. Op code 0 (no operation) is taken without effect and raises no `done`.
- R9: The pointer wraps modulo 2^16 in both directions.
- R10: The following sequence gives 40 at 0FFE, 1A at 0FFF, AB at 0FFC, CD at 0FFD, with the pointer at 0FFC:
  - load 1000;
  - call 401A;
  - word push ABCD.
- R11: No operation ever writes the byte at the address that was loaded into the pointer, until a pull has moved the pointer above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Op code: 0 none, 1 byte push, 2 word push, 3 byte pull, 4 word pull, 5 call, 6 return, 7 load |
| cmd_data | input | 16 | Push value, return address or new pointer |
| busy | output | 1 | Second beat of a word operation in progress |
| done | output | 1 | One-cycle pulse after the last beat of an operation |
| pull_data | output | 16 | Last pulled value |
| stack_ptr | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data for `mem_addr` |

## Verification
Two events can fall in the same cycle: a new command can arrive during the second beat of a word push, and the `done` of that word push can coincide with the acceptance of the next command. The bench provokes both by holding a byte push valid through the whole word push. It then judges the pointer and the memory byte below the word. Both must be untouched in the cycle where `done` appears, and must reflect the byte push exactly one cycle later. Exhaustive byte sweeps, word sweeps and wrap-around cases confirm LIFO order and byte placement against addresses computed in the bench.

// File: rtl/bstk_pkg.sv
package bstk_pkg;

  typedef enum logic [2:0] {
    STK_NOP    = 3'd0,
    STK_PUSH_B = 3'd1,
    STK_PUSH_W = 3'd2,
    STK_PULL_B = 3'd3,
    STK_PULL_W = 3'd4,
    STK_CALL   = 3'd5,
    STK_RET    = 3'd6,
    STK_LOAD   = 3'd7
  } stk_op_e;

  function automatic logic op_pushes(stk_op_e op);
    return (op == STK_PUSH_B) || (op == STK_PUSH_W) || (op == STK_CALL);
  endfunction

  function automatic logic op_pulls(stk_op_e op);
    return (op == STK_PULL_B) || (op == STK_PULL_W) || (op == STK_RET);
  endfunction

  function automatic logic op_wide(stk_op_e op);
    return (op == STK_PUSH_W) || (op == STK_PULL_W) ||
           (op == STK_CALL)   || (op == STK_RET);
  endfunction

endpackage

// File: rtl/bstk_ptr.sv
module bstk_ptr #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_SP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_dn,
  input  logic              step_up,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] sp_below
);

  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] sp_above;

  assign sp_below = sp_q - ADDR_W'(1);
  assign sp_above = sp_q + ADDR_W'(1);
  assign sp       = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp_q <= RESET_SP;
    else if (load_en) sp_q <= load_val;
    else if (step_dn) sp_q <= sp_below;
    else if (step_up) sp_q <= sp_above;
  end

endmodule

// File: rtl/bstk_seq.sv
module bstk_seq
  import bstk_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  stk_op_e           cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              cmd_ready,
  output logic              busy,
  output logic              beat_wr,
  output logic              beat_rd,
  output logic [DATA_W-1:0] wr_byte,
  output logic              load_en,
  output logic              done,
  output logic [WORD_W-1:0] pull_data
);

  logic              second_q;
  stk_op_e           op_q;
  logic [DATA_W-1:0] hold_q;
  logic              done_q;
  logic [WORD_W-1:0] pull_q;
  logic              accept;
  stk_op_e           beat_op;
  logic              last_rd;

  assign accept = cmd_valid && !second_q;

  always_comb begin
    if (second_q)    beat_op = op_q;
    else if (accept) beat_op = cmd_op;
    else             beat_op = STK_NOP;
  end

  assign beat_wr   = op_pushes(beat_op);
  assign beat_rd   = op_pulls(beat_op);
  assign wr_byte   = second_q ? hold_q : cmd_data[DATA_W-1:0];
  assign load_en   = accept && (cmd_op == STK_LOAD);
  assign last_rd   = beat_rd && (second_q || !op_wide(beat_op));
  assign cmd_ready = !second_q;
  assign busy      = second_q;
  assign done      = done_q;
  assign pull_data = pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      op_q     <= STK_NOP;
      hold_q   <= '0;
      done_q   <= 1'b0;
      pull_q   <= '0;
    end else begin
      done_q   <= second_q || (accept && (cmd_op != STK_NOP) && !op_wide(cmd_op));
      second_q <= accept && op_wide(cmd_op);
      if (accept) begin
        op_q   <= cmd_op;
        hold_q <= op_pulls(cmd_op) ? rd_byte : cmd_data[WORD_W-1:DATA_W];
      end
      if (last_rd) begin
        pull_q <= second_q ? {hold_q, rd_byte} : {{DATA_W{1'b0}}, rd_byte};
      end
    end
  end

endmodule

// File: rtl/bstk_port.sv
module bstk_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] sp_below,
  input  logic              beat_wr,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata
);

  assign mem_addr  = beat_wr ? sp_below : sp;
  assign mem_we    = beat_wr;
  assign mem_wdata = beat_wr ? wr_byte : '0;

endmodule

// File: rtl/byte_stack_ctrl.sv
module byte_stack_ctrl
  import bstk_pkg::*;
#(
  parameter  int                ADDR_W   = 16,
  parameter  int                DATA_W   = 8,
  parameter  logic [ADDR_W-1:0] RESET_SP = 16'h1000,
  localparam int                WORD_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] pull_data,
  output logic [ADDR_W-1:0] stack_ptr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              beat_wr;
  logic              beat_rd;
  logic [DATA_W-1:0] wr_byte;
  logic              load_en;
  logic [ADDR_W-1:0] sp;
  logic [ADDR_W-1:0] sp_below;
  logic [ADDR_W-1:0] load_val;

  generate
    if (ADDR_W <= WORD_W) begin : g_load_slice
      assign load_val = cmd_data[ADDR_W-1:0];
    end else begin : g_load_ext
      assign load_val = {{(ADDR_W-WORD_W){1'b0}}, cmd_data};
    end
  endgenerate

  bstk_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (stk_op_e'(cmd_op)),
    .cmd_data  (cmd_data),
    .rd_byte   (mem_rdata),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .beat_wr   (beat_wr),
    .beat_rd   (beat_rd),
    .wr_byte   (wr_byte),
    .load_en   (load_en),
    .done      (done),
    .pull_data (pull_data)
  );

  bstk_ptr #(.ADDR_W(ADDR_W), .RESET_SP(RESET_SP)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_dn  (beat_wr),
    .step_up  (beat_rd),
    .load_en  (load_en),
    .load_val (load_val),
    .sp       (sp),
    .sp_below (sp_below)
  );

  bstk_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .sp        (sp),
    .sp_below  (sp_below),
    .beat_wr   (beat_wr),
    .wr_byte   (wr_byte),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

  assign stack_ptr = sp;

endmodule

// File: rtl/bstk_checker.sv
module bstk_checker #(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 8,
  localparam int WORD_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [WORD_W-1:0] cmd_data,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] stack_ptr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we
);

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  a_r7_no_ready_in_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  a_r7_single_extra_beat: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && done));

  a_r3_pointer_at_written_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (stack_ptr == $past(mem_addr)));

  a_r2_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd7) |=> (stack_ptr == ADDR_W'($past(cmd_data)) && done));

  a_r8_nop_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd0) |=> (!done && $stable(stack_ptr)));

  a_r4_byte_pull_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd3) |=> (stack_ptr == $past(stack_ptr) + ADDR_W'(1)));

endmodule

bind byte_stack_ctrl bstk_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bstk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .busy      (busy),
  .done      (done),
  .stack_ptr (stack_ptr),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we)
);

// File: tb/test_byte_stack_ctrl.sv
`timescale 1ns/1ps
module test_byte_stack_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_data = 16'h0;
  logic        busy, done, mem_we;
  logic [15:0] pull_data, stack_ptr, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic        pre_we = 1'b0;
  logic [11:0] pre_addr = 12'h0;
  logic [7:0]  pre_data = 8'h0;
  logic [7:0]  mem [0:4095];

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  byte_stack_ctrl i_byte_stack_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy), .done(done),
    .pull_data(pull_data), .stack_ptr(stack_ptr), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) begin
    if (mem_we)      mem[mem_addr[11:0]] <= mem_wdata;
    else if (pre_we) mem[pre_addr] <= pre_data;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a[11:0]; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  function automatic logic is_wide(input logic [2:0] op);
    return (op == 3'd2) || (op == 3'd4) || (op == 3'd5) || (op == 3'd6);
  endfunction

  // Leaves the caller at the falling edge where done is visible.
  task automatic run(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (is_wide(op)) @(negedge clk);
  endtask

  function automatic logic [15:0] wpat(input int i);
    return 16'((i * 16'h0403) ^ 16'h3C5A);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp", 32'(stack_ptr), 32'h1000);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 we", 32'(mem_we), 0);
    chk("R1 ready", 32'(cmd_ready), 1);
    rst_n = 1'b1;
    preload(16'h1000, 8'h5A);

    // R2, R5, R10, R11 sequence
    run(3'd7, 16'h1000);
    chk("R2 load sp", 32'(stack_ptr), 32'h1000);
    chk("R2 load done", 32'(done), 1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd5; cmd_data = 16'h401A;
    #1;
    chk("R5 beat1 we", 32'(mem_we), 1);
    chk("R5 beat1 addr", 32'(mem_addr), 32'h0FFF);
    chk("R5 beat1 data", 32'(mem_wdata), 32'h1A);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 busy", 32'(busy), 1);
    chk("R7 ready", 32'(cmd_ready), 0);
    chk("R5 beat2 addr", 32'(mem_addr), 32'h0FFE);
    chk("R5 beat2 data", 32'(mem_wdata), 32'h40);
    @(negedge clk);
    chk("R5 done", 32'(done), 1);
    chk("R5 sp", 32'(stack_ptr), 32'h0FFE);
    run(3'd2, 16'hABCD);
    chk("R10 mem 0FFE", 32'(mem[12'hFFE]), 32'h40);
    chk("R10 mem 0FFF", 32'(mem[12'hFFF]), 32'h1A);
    chk("R10 mem 0FFC", 32'(mem[12'hFFC]), 32'hAB);
    chk("R10 mem 0FFD", 32'(mem[12'hFFD]), 32'hCD);
    chk("R10 sp", 32'(stack_ptr), 32'h0FFC);
    chk("R11 mem 1000", 32'(mem[12'h000]), 32'h5A);

    // R6 word pull and return
    run(3'd4, 16'h0);
    chk("R6 pull data", 32'(pull_data), 32'hABCD);
    chk("R6 pull sp", 32'(stack_ptr), 32'h0FFE);
    chk("R6 pull done", 32'(done), 1);
    run(3'd6, 16'h0);
    chk("R6 ret data", 32'(pull_data), 32'h401A);
    chk("R6 ret sp", 32'(stack_ptr), 32'h1000);

    // R3, R4 exhaustive byte sweep
    run(3'd7, 16'h0900);
    for (int v = 0; v < 256; v++) begin
      run(3'd1, 16'(16'hA500 | v));
      chk("R3 push done", 32'(done), 1);
      chk("R3 push mem", 32'(mem[12'(16'h08FF - v)]), 32'(v));
    end
    chk("R3 sweep sp", 32'(stack_ptr), 32'h0800);
    for (int v = 255; v >= 0; v--) begin
      run(3'd3, 16'h0);
      chk("R4 pull data", 32'(pull_data), 32'(v));
    end
    chk("R4 sweep sp", 32'(stack_ptr), 32'h0900);

    // R5, R6 word sweep
    run(3'd7, 16'h0480);
    for (int i = 0; i < 64; i++) begin
      run(((i % 2) == 0) ? 3'd2 : 3'd5, wpat(i));
      chk("R5 hi byte", 32'(mem[12'(16'h0480 - 2*i - 2)]), 32'(wpat(i) >> 8));
      chk("R5 lo byte", 32'(mem[12'(16'h0480 - 2*i - 1)]), 32'(wpat(i) & 16'hFF));
    end
    chk("R5 sweep sp", 32'(stack_ptr), 32'h0400);
    for (int k = 63; k >= 0; k--) begin
      run(((k % 2) == 0) ? 3'd4 : 3'd6, 16'h0);
      chk("R6 sweep data", 32'(pull_data), 32'(wpat(k)));
    end
    chk("R6 sweep sp", 32'(stack_ptr), 32'h0480);

    // R7, R8 command held through second beat
    run(3'd7, 16'h0700);
    preload(16'h06FD, 8'hEE);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_data = 16'hBEEF;
    @(negedge clk);
    cmd_op = 3'd1; cmd_data = 16'h0077;
    chk("R7 ready low", 32'(cmd_ready), 0);
    @(negedge clk);
    chk("R7 word done", 32'(done), 1);
    chk("R7 sp untouched", 32'(stack_ptr), 32'h06FE);
    chk("R7 mem untouched", 32'(mem[12'h6FD]), 32'hEE);
    chk("R8 ready with done", 32'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 back-to-back done", 32'(done), 1);
    chk("R8 back-to-back sp", 32'(stack_ptr), 32'h06FD);
    chk("R8 back-to-back mem", 32'(mem[12'h6FD]), 32'h77);
    chk("R5 held word hi", 32'(mem[12'h6FE]), 32'hBE);
    chk("R5 held word lo", 32'(mem[12'h6FF]), 32'hEF);
    run(3'd0, 16'h1234);
    chk("R8 nop done", 32'(done), 0);
    chk("R8 nop sp", 32'(stack_ptr), 32'h06FD);

    // R9 wrap
    run(3'd7, 16'h0000);
    run(3'd1, 16'h0011);
    chk("R9 wrap down sp", 32'(stack_ptr), 32'hFFFF);
    chk("R9 wrap down mem", 32'(mem[12'hFFF]), 32'h11);
    run(3'd3, 16'h0);
    chk("R9 wrap up sp", 32'(stack_ptr), 32'h0000);
    chk("R9 wrap up data", 32'(pull_data), 32'h0011);
    run(3'd7, 16'hFFFF);
    run(3'd4, 16'h0);
    chk("R9 word wrap data", 32'(pull_data), 32'h115A);
    chk("R9 word wrap sp", 32'(stack_ptr), 32'h0001);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule